// File: doc/BRIEF.md
# Serial ADC Device Interface Emulator

This block stands in for the digital side of a 12-bit, eight-input serial converter so that host-side serial logic can be verified against something synthesizable. A host drives a serial clock, an active-low chip select and a serial data line. The block finds a start bit in that stream, takes in a seven-bit command and returns a 12-bit result from one of eight parallel sample inputs. The sample inputs take the place of the analog front end. Each sample input holds an offset-binary code.

All host pins are sampled by the fast system clock through two-stage synchronizers, and edges are found from those samples. The serial clock must therefore be much slower than the system clock. The block's two serial outputs can be switched off. Each has a data port and an enable port, and a pad ring or a bench resolves the high-impedance state. SGL/DIF is captured but has no effect on the digital side.

The command is made up of a start bit of 1 and then seven bits. In arrival order these are the channel number (three bits, MSB first), the unipolar flag, the single-ended flag and the two clock-mode bits. The value 11 in the clock-mode bits selects external clocking, which is the only conversion mode built. In that mode the host keeps clocking, and the result comes out one bit per falling serial-clock edge.

Top module: `serial_adc_emu`

## Requirements
- R1: While chip select is high, `dout_oe`, `sstrb_oe` and `acq` are low. This holds from reset, and again within a few system clocks after chip select rises.
- R2: After chip select falls, `dout` and `sstrb` are driven (enables high) with value 0, and `dout` stays 0 until the first result bit.
- R3: With chip select low, 0 bits ahead of the first 1 on `din` are ignored. The first 1 is the start bit, and the next seven rising-edge bits form the command in this order: channel[2:0] (MSB first), unipolar, single-ended, mode[1:0].
- R4: Count rising serial-clock edges from 1 at the start bit. `acq` is high from rising edge 5 until rising edge 8, so it covers the last three command bits.
- R5: With mode = 11, `sstrb` goes high at falling edge 8 and low at falling edge 9, which is one serial-clock period.
- R6: Falling edges 9 to 20 put result bits 11 down to 0 on `dout`, MSB first, and later falling edges put 0. A host that reads on rising edges 9 to 24 therefore sees one 0, the 12 result bits and three 0s.
- R7: The channel field n selects sample input `samples[12*n +: 12]`, latched at rising edge 8.
- R8: When unipolar = 1 the result equals the sample, which is straight binary. When unipolar = 0 the result is the sample with its MSB inverted, which is two's complement.
- R9: If mode is not 11, no strobe is produced, and `dout` stays 0 until chip select rises.
- R10: A chip-select rise part way through a command discards the bits received so far. The next frame decodes as if that partial command had never been sent.
- R11: Once the last result bit has been sent with chip select still low, a new start bit begins a new frame.
- R12: While driven, `dout` changes only as a result of a falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, idle low |
| cs_n | input | 1 | Host chip select, active low |
| din | input | 1 | Host serial data into the block |
| samples | input | 96 | Eight 12-bit offset-binary samples, channel n at bits 12n+11..12n |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| sstrb | output | 1 | End-of-acquisition strobe |
| sstrb_oe | output | 1 | Drive enable for sstrb (0 = high impedance) |
| acq | output | 1 | High during the acquisition window |

## Verification
Commands for every channel number are applied with samples at all-ones, all-zeros, mid-scale and alternating patterns, in both unipolar and bipolar coding. The other seven inputs always hold the complement of the chosen sample, so a wrong channel choice or a wrong MSB inversion changes the bits read back. Start bits that arrive after several leading zeros show that framing is based on the start bit and not on byte boundaries. Further cases cover a non-external mode command, an aborted partial command and two frames sent under one chip select; these tell apart the strobe-suppression, discard and re-arm behaviour.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Frame sequencer phases; PH_OFF must stay the all-zero encoding.
    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_HUNT   = 3'd1,
        PH_CFG    = 3'd2,
        PH_PEND   = 3'd3,
        PH_STROBE = 3'd4,
        PH_SHIFT  = 3'd5,
        PH_HOLD   = 3'd6
    } phase_e;

endpackage

// File: rtl/sadc_pin_sync.sv
// Two-stage synchronizers for the host pins, plus edge detection on bit 0.
module sadc_pin_sync #(
    parameter int            N       = 3,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_lvl,
    output logic         edge_rise,
    output logic         edge_fall
);

    logic [N-1:0] meta_q;
    logic [N-1:0] lvl_q;
    logic         prev_q;

    for (genvar g = 0; g < N; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= RST_VAL[g];
                lvl_q[g]  <= RST_VAL[g];
            end else begin
                meta_q[g] <= pin_in[g];
                lvl_q[g]  <= meta_q[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL[0];
        else        prev_q <= lvl_q[0];
    end

    assign pin_lvl   = lvl_q;
    assign edge_rise = lvl_q[0] & ~prev_q;
    assign edge_fall = ~lvl_q[0] & prev_q;

endmodule

// File: rtl/sadc_sample_pick.sv
// Channel selection and output coding of the parallel sample inputs.
module sadc_sample_pick #(
    parameter int CH_N     = 8,
    parameter int SAMPLE_W = 12,
    localparam int SEL_W   = $clog2(CH_N)
) (
    input  logic [CH_N*SAMPLE_W-1:0] samples,
    input  logic [SEL_W-1:0]         sel,
    input  logic                     unipolar,
    output logic [SAMPLE_W-1:0]      code
);

    logic [SAMPLE_W-1:0] lane [CH_N];
    logic [SAMPLE_W-1:0] picked;

    for (genvar g = 0; g < CH_N; g++) begin : g_lane
        assign lane[g] = samples[g*SAMPLE_W +: SAMPLE_W];
    end

    assign picked = lane[sel];

    // Offset binary -> two's complement is an MSB inversion.
    always_comb begin
        if (unipolar) code = picked;
        else          code = {~picked[SAMPLE_W-1], picked[SAMPLE_W-2:0]};
    end

endmodule

// File: rtl/sadc_frame.sv
// Start-bit hunt, command capture, strobe and result shifting.
module sadc_frame
    import sadc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int SEL_W    = 3,
    localparam int CFG_W   = SEL_W + 4,
    localparam int MAX_CNT = (SAMPLE_W > CFG_W) ? SAMPLE_W : CFG_W,
    localparam int CNT_W   = $clog2(MAX_CNT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_lvl,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic                din_lvl,
    input  logic [SAMPLE_W-1:0] code,
    output logic [SEL_W-1:0]    sel,
    output logic                unipolar,
    output logic                dout,
    output logic                dout_oe,
    output logic                sstrb,
    output logic                sstrb_oe,
    output logic                acq
);

    // Captured-bit count at which the acquisition window opens / closes.
    localparam logic [CNT_W-1:0] ACQ_OPEN  = CNT_W'(CFG_W - 4);
    localparam logic [CNT_W-1:0] CFG_LAST  = CNT_W'(CFG_W - 1);
    localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(SAMPLE_W);

    typedef struct packed {
        phase_e              phase;
        logic [CFG_W-2:0]    cfg;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] word;
        logic                dout;
        logic                oe;
        logic                sstrb;
        logic                acq;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (cs_lvl) begin
            fr_d = '0;
        end else begin
            case (fr_q.phase)
                PH_OFF: begin
                    fr_d.phase = PH_HUNT;
                    fr_d.oe    = 1'b1;
                end
                PH_HUNT: begin
                    if (sclk_rise && din_lvl) begin
                        fr_d.phase = PH_CFG;
                        fr_d.cnt   = '0;
                        fr_d.cfg   = '0;
                    end
                end
                PH_CFG: begin
                    if (sclk_rise) begin
                        fr_d.cfg = {fr_q.cfg[CFG_W-3:0], din_lvl};
                        fr_d.cnt = fr_q.cnt + 1'b1;
                        if (fr_q.cnt == ACQ_OPEN) fr_d.acq = 1'b1;
                        if (fr_q.cnt == CFG_LAST) begin
                            fr_d.acq   = 1'b0;
                            fr_d.cfg   = fr_q.cfg;
                            fr_d.word  = code;
                            fr_d.cnt   = '0;
                            fr_d.phase = (fr_q.cfg[0] && din_lvl) ? PH_PEND : PH_HOLD;
                        end
                    end
                end
                PH_PEND: begin
                    if (sclk_fall) begin
                        fr_d.sstrb = 1'b1;
                        fr_d.phase = PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    if (sclk_fall) begin
                        fr_d.sstrb = 1'b0;
                        fr_d.dout  = fr_q.word[SAMPLE_W-1];
                        fr_d.word  = {fr_q.word[SAMPLE_W-2:0], 1'b0};
                        fr_d.cnt   = CNT_W'(1);
                        fr_d.phase = PH_SHIFT;
                    end
                end
                PH_SHIFT: begin
                    if (sclk_fall) begin
                        if (fr_q.cnt == BITS_DONE) begin
                            fr_d.dout  = 1'b0;
                            fr_d.phase = PH_HUNT;
                        end else begin
                            fr_d.dout = fr_q.word[SAMPLE_W-1];
                            fr_d.word = {fr_q.word[SAMPLE_W-2:0], 1'b0};
                            fr_d.cnt  = fr_q.cnt + 1'b1;
                        end
                    end
                end
                PH_HOLD: ;
                default: fr_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign sel      = fr_q.cfg[CFG_W-2 -: SEL_W];
    assign unipolar = fr_q.cfg[CFG_W-2-SEL_W];
    assign dout     = fr_q.dout;
    assign dout_oe  = fr_q.oe;
    assign sstrb    = fr_q.sstrb;
    assign sstrb_oe = fr_q.oe;
    assign acq      = fr_q.acq;

endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu #(
    parameter int CH_N     = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     din,
    input  logic [CH_N*SAMPLE_W-1:0] samples,
    output logic                     dout,
    output logic                     dout_oe,
    output logic                     sstrb,
    output logic                     sstrb_oe,
    output logic                     acq
);

    localparam int SEL_W = $clog2(CH_N);

    logic [2:0]          pin_lvl;
    logic                cs_lvl;
    logic                din_lvl;
    logic                sclk_rise;
    logic                sclk_fall;
    logic [SEL_W-1:0]    sel;
    logic                unipolar;
    logic [SAMPLE_W-1:0] code;

    // Bit 0 is the serial clock (edges found), bit 1 chip select, bit 2 data.
    sadc_pin_sync #(
        .N       (3),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    ({din, cs_n, sclk}),
        .pin_lvl   (pin_lvl),
        .edge_rise (sclk_rise),
        .edge_fall (sclk_fall)
    );

    assign cs_lvl  = pin_lvl[1];
    assign din_lvl = pin_lvl[2];

    sadc_sample_pick #(
        .CH_N     (CH_N),
        .SAMPLE_W (SAMPLE_W)
    ) u_pick (
        .samples  (samples),
        .sel      (sel),
        .unipolar (unipolar),
        .code     (code)
    );

    sadc_frame #(
        .SAMPLE_W (SAMPLE_W),
        .SEL_W    (SEL_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (cs_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_lvl   (din_lvl),
        .code      (code),
        .sel       (sel),
        .unipolar  (unipolar),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .sstrb     (sstrb),
        .sstrb_oe  (sstrb_oe),
        .acq       (acq)
    );

endmodule

// File: rtl/sadc_checks.sv
module sadc_checks (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic sclk_fall,
    input logic dout,
    input logic dout_oe,
    input logic sstrb,
    input logic sstrb_oe,
    input logic acq
);

    a_r1_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (!dout_oe && !sstrb_oe && !acq));

    a_r5_strobe_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sstrb) |-> $past(sclk_fall));

    a_r5_strobe_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sstrb && sclk_fall) |=> !sstrb);

    a_r12_dout_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe) && !$stable(dout)) |-> $past(sclk_fall));

    a_r4_acq_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        acq |-> (!sstrb && !dout));

    a_r2_dout_low_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sstrb |-> !dout);

endmodule

bind serial_adc_emu sadc_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (cs_lvl),
    .sclk_fall (sclk_fall),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .sstrb     (sstrb),
    .sstrb_oe  (sstrb_oe),
    .acq       (acq)
);

// File: tb/serial_adc_emu_bench.sv
module serial_adc_emu_bench;

    localparam int HALF = 6;   // system clocks per serial-clock half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic [95:0] samples = '0;
    logic        dout, dout_oe, sstrb, sstrb_oe, acq;

    logic [31:0] rx, st, aq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    serial_adc_emu u_serial_adc_emu (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .din      (din),
        .samples  (samples),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .sstrb    (sstrb),
        .sstrb_oe (sstrb_oe),
        .acq      (acq)
    );

    // {channel[2:0], unipolar, sample[11:0]}
    localparam logic [15:0] VEC [0:7] = '{
        {3'd0, 1'b1, 12'hABC},
        {3'd7, 1'b1, 12'hFFF},
        {3'd1, 1'b1, 12'h000},
        {3'd2, 1'b0, 12'h800},
        {3'd3, 1'b0, 12'h7FF},
        {3'd4, 1'b0, 12'h000},
        {3'd5, 1'b1, 12'h555},
        {3'd6, 1'b0, 12'hA5A}
    };

    localparam logic [31:0] ST_EXP = 32'h0008_0000;  // high only at read 9
    localparam logic [31:0] AQ_EXP = 32'h0070_0000;  // high at reads 6, 7, 8

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_of(input logic [2:0] ch, input logic uni, input logic [1:0] md);
        return {1'b1, ch, uni, 1'b1, md};
    endfunction

    function automatic logic [31:0] rx_exp(input logic uni, input logic [11:0] s);
        logic [11:0] c;
        c = uni ? s : (s ^ 12'h800);
        return {12'h000, 1'b0, c, 7'b0};
    endfunction

    // Put value s on channel ch and the complement on every other channel.
    task automatic load(input logic [2:0] ch, input logic [11:0] s);
        for (int k = 0; k < 8; k++)
            samples[k*12 +: 12] = (k == int'(ch)) ? s : ~s;
    endtask

    // One serial bit: the host reads dout just before the rising edge.
    task automatic clk_bit(input logic b);
        din = b;
        repeat (HALF) @(negedge clk);
        rx = {rx[30:0], dout};
        st = {st[30:0], sstrb};
        aq = {aq[30:0], acq};
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        rx = '0; st = '0; aq = '0;
        for (int i = n - 1; i >= 0; i--) clk_bit(bits[i]);
        din = 1'b0;
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state with chip select high
        chk("R1 reset enables/acq", {29'd0, dout_oe, sstrb_oe, acq}, 32'd0);

        // R2: driven low after chip select falls
        cs_low();
        chk("R2 driven low after select", {28'd0, dout_oe, sstrb_oe, dout, sstrb}, 32'hC);
        cs_high();

        // Table walk: R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            load(VEC[v][15:13], VEC[v][11:0]);
            cs_low();
            frame({4'h0, ctrl_of(VEC[v][15:13], VEC[v][12], 2'b11), 20'h0}, 28);
            chk($sformatf("R6/R7/R8 result vec%0d", v), rx, rx_exp(VEC[v][12], VEC[v][11:0]));
            chk($sformatf("R5 strobe vec%0d", v), st, ST_EXP);
            chk($sformatf("R4 acq window vec%0d", v), aq, AQ_EXP);
            cs_high();
            chk($sformatf("R1 released vec%0d", v), {30'd0, dout_oe, sstrb_oe}, 32'd0);
        end

        // R3: start bit after three leading zeros
        load(3'd2, 12'h123);
        cs_low();
        frame({4'h0, ctrl_of(3'd2, 1'b1, 2'b11), 20'h0}, 31);
        chk("R3 late start result", rx, rx_exp(1'b1, 12'h123));
        chk("R3 late start strobe", st, ST_EXP);
        cs_high();

        // R9: non-external mode gives no strobe and no data
        load(3'd0, 12'hFFF);
        cs_low();
        frame({4'h0, ctrl_of(3'd0, 1'b1, 2'b01), 20'h0}, 28);
        chk("R9 no data", rx, 32'd0);
        chk("R9 no strobe", st, 32'd0);
        chk("R9 still driven", {30'd0, dout_oe, sstrb_oe}, 32'h3);
        cs_high();

        // R10: partial command aborted by chip select
        load(3'd0, 12'h9C3);
        cs_low();
        frame(32'hF, 4);
        cs_high();
        chk("R10 released after abort", {30'd0, dout_oe, sstrb_oe}, 32'd0);
        cs_low();
        frame({4'h0, ctrl_of(3'd0, 1'b1, 2'b11), 20'h0}, 28);
        chk("R10 clean frame after abort", rx, rx_exp(1'b1, 12'h9C3));
        cs_high();

        // R11: two frames under one chip select
        load(3'd1, 12'h321);
        cs_low();
        frame({4'h0, ctrl_of(3'd1, 1'b1, 2'b11), 20'h0}, 28);
        chk("R11 first frame", rx, rx_exp(1'b1, 12'h321));
        load(3'd6, 12'h0F0);
        frame({4'h0, ctrl_of(3'd6, 1'b0, 2'b11), 20'h0}, 28);
        chk("R11 second frame", rx, rx_exp(1'b0, 12'h0F0));
        chk("R11 second strobe", st, ST_EXP);
        cs_high();
        chk("R1 final release", {29'd0, dout_oe, sstrb_oe, acq}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule